// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a 16-bit virtual address into a physical byte address for a memory-managed processor. The upper three address bits pick one of eight pages and the lower thirteen bits are the offset inside it. Outside logic reads the selected page's base word and descriptor word for the current run mode and presents them with the request. The translator then forms the physical address and decides whether the access is allowed.

When mapping is disabled, the address passes through unchanged and no checks run. When mapping is enabled, the block checks three things: the access code held in the descriptor, whether the physical address lies within the installed memory, and the page length. The length check can grow the page upward from offset zero or downward from the top of the page. Every fault gives a trap vector and a set of status and descriptor bits to set. The register file applies those bits. A peek request translates the address but changes nothing.

Results are registered. Each request gives one result one cycle later. A fault appears as a pulse that lasts a single cycle.

Top module: `vat_xlate`

## Requirements
- R1: When `map_en` is low, `paddr` equals the zero-extended `vaddr`, and no fault, status or descriptor strobe is raised.
- R2: When `map_en` is high, `paddr` = `page_base` × 64 + `vaddr[12:0]`, and `page_idx` = `vaddr[15:13]`.
- R3: `run_mode` is `cpu_status[15:14]`, or `cpu_status[13:12]` when `use_prev` is high. The run mode is reported on every result.
- R4: With `chk_en` high, the access code `page_desc[2:0]` allows a write only for code 6 and refuses a read for codes 0, 1, 3, 4 and 7. With `chk_en` low, the access code is ignored.
- R5: An access-code fault pulses `fault` with `fault_vec` = octal 004 and `stat_set` = 4'b0011 (bit 0 is status bit 12, bit 1 is status bit 13). It also raises `mode_wr`, with `mode_val` equal to the run mode for status bits 6:5, and raises `desc_err_set` for descriptor bit 7.
- R6: When `page_desc[3]` is 0, an offset at or above (`page_desc[14:8]` + 1) × 64 bytes is a length fault.
- R7: When `page_desc[3]` is 1, an offset below (`page_desc[14:8]` + 1) × 64 bytes is a length fault.
- R8: A length fault pulses `fault` with `fault_vec` = octal 250, `stat_set` = 4'b0100 (status bit 14), and `desc_err_set`, with `mode_wr` low.
- R9: A physical address at or above `MEM_BYTES` (131072 by default) is a non-resident fault. It gives `fault_vec` = octal 004, `stat_set` = 4'b1000 (status bit 15), and `desc_err_set`, with `mode_wr` low.
- R10: If several faults apply, only the highest-priority one is reported. The order is access code first, then non-resident, then length.
- R11: With `peek` high, the address is still translated, but no fault and no strobe is raised.
- R12: The outputs are registered. `res_valid` and any fault follow a `req_valid` by exactly one cycle and last one cycle. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is present |
| vaddr | input | 16 | Virtual address |
| is_write | input | 1 | 1 = write access, 0 = read access |
| peek | input | 1 | Translate without checks or side effects |
| cpu_status | input | 16 | Processor status word |
| use_prev | input | 1 | Take the run mode from the previous-mode field |
| map_en | input | 1 | Mapping enable (status register 0 bit 0) |
| chk_en | input | 1 | Access-code check enable (status register 0 bit 9) |
| page_base | input | 16 | Base word of the selected page, in 64-byte units |
| page_desc | input | 16 | Descriptor word of the selected page |
| res_valid | output | 1 | Result is valid this cycle |
| paddr | output | 22 | Physical byte address |
| page_idx | output | 3 | Page number of the request |
| run_mode | output | 2 | Run mode used for the request |
| fault | output | 1 | One-cycle fault pulse |
| fault_vec | output | 8 | Trap vector of the fault |
| stat_set | output | 4 | Status register 0 bits 15:12 to set |
| mode_wr | output | 1 | Write `mode_val` into status bits 6:5 |
| mode_val | output | 2 | Run mode to record |
| desc_err_set | output | 1 | Set bit 7 of the selected descriptor |

## Verification
On every cycle, the assertions check the following:
- the one-cycle result latency and the single-cycle fault pulse;
- that at most one fault class is reported;
- that the vector matches the status bits set;
- that peek and unmapped requests stay silent, and that unmapped requests pass the address through.

Only the bench's vector scenarios can show the arithmetic and the boundaries:
- that the physical address sum is right;
- which access codes fault for reads and for writes;
- the exact byte where an upward or downward page boundary trips;
- the memory limit edge;
- the run mode chosen when `use_prev` is set.

// File: rtl/vat_pkg.sv
package vat_pkg;

  typedef enum logic [1:0] {
    FK_NONE   = 2'd0,
    FK_ACCESS = 2'd1,
    FK_NONRES = 2'd2,
    FK_LENGTH = 2'd3
  } fault_kind_e;

  localparam logic [7:0] VEC_ABORT  = 8'o004;
  localparam logic [7:0] VEC_LENGTH = 8'o250;

  // Access code check for a read.
  function automatic logic read_refused(input logic [2:0] code);
    case (code)
      3'd0, 3'd1, 3'd3, 3'd4, 3'd7: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  // Only full read/write pages accept stores.
  function automatic logic write_refused(input logic [2:0] code);
    return code != 3'd6;
  endfunction

  // Page length in bytes from the 7-bit block count field.
  function automatic logic [14:0] page_len_bytes(input logic [6:0] blocks);
    return (15'(blocks) + 15'd1) << 6;
  endfunction

  // Status-bit set mask (bits 15:12 of status register 0) per fault kind.
  function automatic logic [3:0] stat_mask(input fault_kind_e k);
    case (k)
      FK_ACCESS: return 4'b0011;
      FK_NONRES: return 4'b1000;
      FK_LENGTH: return 4'b0100;
      default:   return 4'b0000;
    endcase
  endfunction

  function automatic logic [7:0] trap_vector(input fault_kind_e k);
    return (k == FK_LENGTH) ? VEC_LENGTH : VEC_ABORT;
  endfunction

endpackage

// File: rtl/vat_mode_sel.sv
module vat_mode_sel (
  input  logic [15:0] cpu_status,
  input  logic        use_prev,
  output logic [1:0]  mode
);
  always_comb begin
    mode = use_prev ? cpu_status[13:12] : cpu_status[15:14];
  end

  logic [11:0] unused_status_bits;
  assign unused_status_bits = cpu_status[11:0];
endmodule

// File: rtl/vat_addr_map.sv
module vat_addr_map #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 13,
  parameter int BLK_W = 6,
  parameter int BASE_W = 16,
  parameter int PA_W  = BASE_W + BLK_W,
  localparam int PG_W = VA_W - OFF_W
) (
  input  logic              map_on,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [BASE_W-1:0] base,
  output logic [PA_W-1:0]   paddr,
  output logic [PG_W-1:0]   page,
  output logic [OFF_W-1:0]  offset
);
  assign page   = vaddr[VA_W-1:OFF_W];
  assign offset = vaddr[OFF_W-1:0];

  logic [PA_W-1:0] mapped_sum;
  assign mapped_sum = (PA_W'(base) << BLK_W) + PA_W'(offset);

  always_comb begin
    paddr = map_on ? mapped_sum : PA_W'(vaddr);
  end
endmodule

// File: rtl/vat_fault_chk.sv
module vat_fault_chk
  import vat_pkg::*;
#(
  parameter int OFF_W     = 13,
  parameter int PA_W      = 22,
  parameter int MEM_BYTES = 131072
) (
  input  logic             map_on,
  input  logic             chk_en,
  input  logic             is_write,
  input  logic             peek,
  input  logic [15:0]      desc,
  input  logic [OFF_W-1:0] offset,
  input  logic [PA_W-1:0]  paddr,
  output fault_kind_e      kind
);
  localparam logic [PA_W:0] MEM_LIMIT = (PA_W+1)'(MEM_BYTES);

  logic        active;
  logic        acc_bad, res_bad, len_bad;
  logic [14:0] len_bytes;
  logic [14:0] off_ext;

  assign active    = map_on && !peek;
  assign len_bytes = page_len_bytes(desc[14:8]);
  assign off_ext   = 15'(offset);

  assign acc_bad = chk_en && (is_write ? write_refused(desc[2:0])
                                       : read_refused(desc[2:0]));
  assign res_bad = {1'b0, paddr} >= MEM_LIMIT;
  assign len_bad = desc[3] ? (off_ext < len_bytes) : (off_ext >= len_bytes);

  always_comb begin
    if (!active)      kind = FK_NONE;
    else if (acc_bad) kind = FK_ACCESS;
    else if (res_bad) kind = FK_NONRES;
    else if (len_bad) kind = FK_LENGTH;
    else              kind = FK_NONE;
  end

  logic [4:0] unused_desc_bits;
  assign unused_desc_bits = {desc[15], desc[7:4]};
endmodule

// File: rtl/vat_xlate.sv
module vat_xlate
  import vat_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int OFF_W     = 13,
  parameter int BLK_W     = 6,
  parameter int MEM_BYTES = 131072,
  localparam int PA_W     = 16 + BLK_W,
  localparam int PG_W     = VA_W - OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] vaddr,
  input  logic            is_write,
  input  logic            peek,
  input  logic [15:0]     cpu_status,
  input  logic            use_prev,
  input  logic            map_en,
  input  logic            chk_en,
  input  logic [15:0]     page_base,
  input  logic [15:0]     page_desc,
  output logic            res_valid,
  output logic [PA_W-1:0] paddr,
  output logic [PG_W-1:0] page_idx,
  output logic [1:0]      run_mode,
  output logic            fault,
  output logic [7:0]      fault_vec,
  output logic [3:0]      stat_set,
  output logic            mode_wr,
  output logic [1:0]      mode_val,
  output logic            desc_err_set
);
  logic [1:0]       mode_d;
  logic [PA_W-1:0]  pa_d;
  logic [PG_W-1:0]  page_d;
  logic [OFF_W-1:0] off_d;
  fault_kind_e      kind_d;
  logic             flt_event;

  vat_mode_sel u_mode (
    .cpu_status (cpu_status),
    .use_prev   (use_prev),
    .mode       (mode_d)
  );

  vat_addr_map #(
    .VA_W   (VA_W),
    .OFF_W  (OFF_W),
    .BLK_W  (BLK_W),
    .BASE_W (16),
    .PA_W   (PA_W)
  ) u_map (
    .map_on (map_en),
    .vaddr  (vaddr),
    .base   (page_base),
    .paddr  (pa_d),
    .page   (page_d),
    .offset (off_d)
  );

  vat_fault_chk #(
    .OFF_W     (OFF_W),
    .PA_W      (PA_W),
    .MEM_BYTES (MEM_BYTES)
  ) u_chk (
    .map_on   (map_en),
    .chk_en   (chk_en),
    .is_write (is_write),
    .peek     (peek),
    .desc     (page_desc),
    .offset   (off_d),
    .paddr    (pa_d),
    .kind     (kind_d)
  );

  assign flt_event = req_valid && (kind_d != FK_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      paddr        <= '0;
      page_idx     <= '0;
      run_mode     <= 2'd0;
      fault        <= 1'b0;
      fault_vec    <= 8'd0;
      stat_set     <= 4'd0;
      mode_wr      <= 1'b0;
      mode_val     <= 2'd0;
      desc_err_set <= 1'b0;
    end else begin
      res_valid    <= req_valid;
      fault        <= flt_event;
      desc_err_set <= flt_event;
      fault_vec    <= flt_event ? trap_vector(kind_d) : 8'd0;
      stat_set     <= flt_event ? stat_mask(kind_d) : 4'd0;
      mode_wr      <= flt_event && (kind_d == FK_ACCESS);
      mode_val     <= (flt_event && kind_d == FK_ACCESS) ? mode_d : 2'd0;
      if (req_valid) begin
        paddr    <= pa_d;
        page_idx <= page_d;
        run_mode <= mode_d;
      end
    end
  end

  // R12
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  // R12
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && !fault);
  // R10
  single_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_set[3], stat_set[2], stat_set[1]}) && (fault == (stat_set != 4'd0)));
  // R8
  len_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_vec == VEC_LENGTH) |-> (stat_set == 4'b0100 && desc_err_set && !mode_wr));
  // R5
  acc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |-> (fault && stat_set == 4'b0011 && fault_vec == VEC_ABORT));
  // R11
  peek_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && peek) |=> (!fault && !desc_err_set && !mode_wr));
  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !map_en) |=> (paddr == PA_W'($past(vaddr)) && !fault));
endmodule

// File: tb/tb_vat_xlate.sv
`timescale 1ns/1ps
module tb_vat_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] vaddr = '0;
  logic        is_write = 1'b0;
  logic        peek = 1'b0;
  logic [15:0] cpu_status = '0;
  logic        use_prev = 1'b0;
  logic        map_en = 1'b0;
  logic        chk_en = 1'b0;
  logic [15:0] page_base = '0;
  logic [15:0] page_desc = '0;
  logic        res_valid;
  logic [21:0] paddr;
  logic [2:0]  page_idx;
  logic [1:0]  run_mode;
  logic        fault;
  logic [7:0]  fault_vec;
  logic [3:0]  stat_set;
  logic        mode_wr;
  logic [1:0]  mode_val;
  logic        desc_err_set;

  always #2 clk = ~clk;

  vat_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
    .is_write(is_write), .peek(peek), .cpu_status(cpu_status),
    .use_prev(use_prev), .map_en(map_en), .chk_en(chk_en),
    .page_base(page_base), .page_desc(page_desc), .res_valid(res_valid),
    .paddr(paddr), .page_idx(page_idx), .run_mode(run_mode), .fault(fault),
    .fault_vec(fault_vec), .stat_set(stat_set), .mode_wr(mode_wr),
    .mode_val(mode_val), .desc_err_set(desc_err_set)
  );

  // kind: 0 none, 1 access code, 2 non-resident, 3 length
  typedef struct packed {
    logic [15:0] sw;
    logic        prev;
    logic        en;
    logic        chk;
    logic        wr;
    logic        pk;
    logic [15:0] par;
    logic [15:0] pdr;
    logic [15:0] va;
    logic [1:0]  kind;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0800, 16'h0000, 16'h1234, 2'd0}, // R1 off
    '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h7F06, 16'h2345, 2'd0}, // R2
    '{16'h8000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0200, 16'h7F06, 16'hE010, 2'd0}, // R2 R4 write ok
    '{16'hC000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0100, 16'h7F02, 16'h4000, 2'd1}, // R4 R5 write ro
    '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h7F02, 16'h4000, 2'd0}, // R4 read ro
    '{16'h4000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h7F04, 16'h4000, 2'd1}, // R4 code 4
    '{16'h2000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h7F00, 16'h4000, 2'd1}, // R3 R4 code 0
    '{16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0100, 16'h7F00, 16'h0000, 2'd0}, // R4 chk off
    '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0010, 16'h0306, 16'h00FF, 2'd0}, // R6 last byte
    '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0010, 16'h0306, 16'h0100, 2'd3}, // R6 R8 over
    '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0010, 16'h030E, 16'h00FF, 2'd3}, // R7 below
    '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0010, 16'h030E, 16'h0100, 2'd0}, // R7 edge ok
    '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0800, 16'h7F06, 16'h0000, 2'd2}, // R9 limit
    '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h07FF, 16'h7F06, 16'h003F, 2'd0}, // R9 top byte
    '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0800, 16'h0002, 16'h1000, 2'd1}, // R10 all three
    '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0800, 16'h0006, 16'h1000, 2'd2}, // R10 nonres>len
    '{16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0800, 16'h0000, 16'h0000, 2'd0}, // R11 peek
    '{16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0040, 2'd3}  // R4 R6 chk off len
  };

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset valid", {31'd0, res_valid}, 0);
    check("R12 reset fault", {31'd0, fault}, 0);
    check("R12 reset paddr", {10'd0, paddr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [1:0]  e_mode;
      logic [31:0] e_pa;
      logic [3:0]  e_stat;
      logic [7:0]  e_vec;
      v = TBL[i];
      e_mode = v.prev ? v.sw[13:12] : v.sw[15:14];
      e_pa = v.en ? (32'(v.par) * 64 + 32'(v.va[12:0])) : 32'(v.va);
      case (v.kind)
        2'd1: begin e_stat = 4'b0011; e_vec = 8'o004; end
        2'd2: begin e_stat = 4'b1000; e_vec = 8'o004; end
        2'd3: begin e_stat = 4'b0100; e_vec = 8'o250; end
        default: begin e_stat = 4'b0000; e_vec = 8'd0; end
      endcase
      cpu_status = v.sw; use_prev = v.prev; map_en = v.en; chk_en = v.chk;
      is_write = v.wr; peek = v.pk; page_base = v.par; page_desc = v.pdr;
      vaddr = v.va; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R12 valid v%0d", i), {31'd0, res_valid}, 1);
      check($sformatf("R2 paddr v%0d", i), {10'd0, paddr}, e_pa);
      check($sformatf("R2 page v%0d", i), {29'd0, page_idx}, {29'd0, v.va[15:13]});
      check($sformatf("R3 mode v%0d", i), {30'd0, run_mode}, {30'd0, e_mode});
      check($sformatf("R10 fault v%0d", i), {31'd0, fault}, {31'd0, v.kind != 2'd0});
      check($sformatf("R5 R8 R9 vec v%0d", i), {24'd0, fault_vec}, {24'd0, e_vec});
      check($sformatf("R5 R8 R9 stat v%0d", i), {28'd0, stat_set}, {28'd0, e_stat});
      check($sformatf("R5 modewr v%0d", i), {31'd0, mode_wr}, {31'd0, v.kind == 2'd1});
      if (v.kind == 2'd1)
        check($sformatf("R5 modeval v%0d", i), {30'd0, mode_val}, {30'd0, e_mode});
      check($sformatf("R8 desc v%0d", i), {31'd0, desc_err_set}, {31'd0, v.kind != 2'd0});
      @(negedge clk);
      check($sformatf("R12 pulse end v%0d", i), {30'd0, fault, res_valid}, 0);
    end

    // R12: back-to-back fault then clean request
    map_en = 1'b1; chk_en = 1'b1; is_write = 1'b1; peek = 1'b0;
    page_base = 16'h0001; page_desc = 16'h7F02; vaddr = 16'h0002; req_valid = 1'b1;
    @(negedge clk);
    check("R12 b2b first fault", {31'd0, fault}, 1);
    page_desc = 16'h7F06;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 b2b second clean", {31'd0, fault}, 0);
    check("R12 b2b second valid", {31'd0, res_valid}, 1);
    check("R2 b2b paddr", {10'd0, paddr}, 32'h42);

    // R12: reset mid-stream clears outputs
    page_desc = 16'h7F00; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset clears fault", {31'd0, fault}, 0);
    check("R12 reset clears stat", {28'd0, stat_set}, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule